// File: doc/BRIEF.md
# Raster Sync and Scan Position Generator

This block sets the raster timing of one display pipe. Running on the pixel clock, it keeps a pixel column counter and a line counter, and it builds the horizontal and vertical sync pulses from start and end positions that software programs. Each sync pulse has its own enable bit and its own polarity-invert bit. The block also drives a data-enable signal for the visible area and a one-cycle pulse at the start of vertical blanking.

The current column and line are always readable as one packed 32-bit word. A free-running counter records the number of blanking intervals produced since reset. Software can use these two values to place updates relative to the beam or to measure the frame rate. All timing values are plain inputs. They are expected to stay stable while the block runs, and are changed only while reset is held.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted, the scan position word reads 0 and the blanking counter reads 0.
- R2: The column counter X steps by one per clock and returns to 0 on the clock after it reaches h_total-1.
- R3: The line counter Y advances by one only on the clock where X returns to 0, and it returns to 0 after line v_total-1.
- R4: The horizontal sync word holds its start position in bits [12:0] and its end position in bits [28:16]. The pulse is active while start <= X < end.
- R5: The vertical sync word holds its start position in bits [11:0] and its end position in bits [27:16]. The pulse is active while start <= Y < end.
- R6: Bit 30 of each sync word enables that output. When the bit is 0, the output stays at its inactive level, which is the value of bit 31.
- R7: Bit 31 of each sync word inverts the output. Without inversion, an active pulse is driven high and an inactive one low.
- R8: Data-enable is high exactly when X < h_active and Y < v_active.
- R9: The blanking pulse is high for the single cycle where Y equals v_active and X is 0. When v_active >= v_total, it never fires.
- R10: The blanking counter rises by exactly one on the clock after each blanking pulse.
- R11: The scan position word carries X, zero-extended, in bits [31:16] and Y, zero-extended, in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total | input | 13 | Clocks per line, at least 2 |
| h_active | input | 13 | Visible pixels per line |
| v_total | input | 12 | Lines per frame, at least 1 |
| v_active | input | 12 | Visible lines per frame |
| hsync_cfg | input | 32 | Horizontal sync start, end, enable and invert |
| vsync_cfg | input | 32 | Vertical sync start, end, enable and invert |
| hsync | output | 1 | Horizontal sync output |
| vsync | output | 1 | Vertical sync output |
| de | output | 1 | Data-enable for the visible area |
| vblank_pulse | output | 1 | One-cycle start-of-blanking pulse |
| scan_pos | output | 32 | Packed current X and Y |
| vblank_count | output | 16 | Number of blanking pulses since reset |

## Verification
The bench keeps the default counter widths and applies tiny rasters, with lines of 10 or 7 clocks and frames of 6 or 5 lines. At that size a run of a few frames passes through every (X, Y) pair, so every wrap, every sync edge and every blanking pulse is checked cycle by cycle against an arithmetic model. Separate configurations cover inversion, a disabled sync, an empty window with start equal to end, and v_active beyond v_total. With such short frames, several blanking pulses fit in one run, so the counter is seen to step more than once.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned END_LSB = 16;
  localparam int unsigned EN_BIT  = 30;
  localparam int unsigned INV_BIT = 31;

  // Half-open window test: start <= c < stop
  function automatic logic in_window(input logic [15:0] c,
                                     input logic [15:0] start,
                                     input logic [15:0] stop);
    return (c >= start) && (c < stop);
  endfunction

  // Pin level from activity, enable and polarity
  function automatic logic pin_level(input logic active,
                                     input logic en,
                                     input logic inv);
    return en ? (active ^ inv) : inv;
  endfunction
endpackage

// File: rtl/rtg_scan_counter.sv
module rtg_scan_counter #(
  parameter int unsigned XW = 13,
  parameter int unsigned YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] h_total,
  input  logic [YW-1:0] v_total,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          h_wrap
);
  logic v_last;

  assign h_wrap = (x >= h_total - XW'(1));
  assign v_last = (y >= v_total - YW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else begin
      x <= h_wrap ? '0 : x + XW'(1);
      if (h_wrap) y <= v_last ? '0 : y + YW'(1);
    end
  end

  p_x_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x == h_total - XW'(1)) |=> (x == '0));
  p_x_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x < h_total - XW'(1)) |=> (x == $past(x) + XW'(1)));
  p_y_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(y));
  p_y_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && y == v_total - YW'(1)) |=> (y == '0));
endmodule

// File: rtl/rtg_sync_decode.sv
module rtg_sync_decode
  import rtg_pkg::*;
#(
  parameter int unsigned CW = 13
) (
  input  logic [CW-1:0]    cnt,
  input  logic [CFG_W-1:0] cfg,
  output logic             sync_o
);
  logic [CW-1:0] start_pos;
  logic [CW-1:0] stop_pos;
  logic          active;

  assign start_pos = cfg[CW-1:0];
  assign stop_pos  = cfg[END_LSB+CW-1:END_LSB];
  assign active    = in_window(16'(cnt), 16'(start_pos), 16'(stop_pos));
  assign sync_o    = pin_level(active, cfg[EN_BIT], cfg[INV_BIT]);

  always_comb begin
    p_empty_window_r4: assert (!(start_pos >= stop_pos) || sync_o == cfg[INV_BIT]);
  end
endmodule

// File: rtl/rtg_blank_counter.sv
module rtg_blank_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  p_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + CNT_W'(1)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned XW    = 13,
  parameter int unsigned YW    = 12,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW-1:0]    h_total,
  input  logic [XW-1:0]    h_active,
  input  logic [YW-1:0]    v_total,
  input  logic [YW-1:0]    v_active,
  input  logic [31:0]      hsync_cfg,
  input  logic [31:0]      vsync_cfg,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             vblank_pulse,
  output logic [31:0]      scan_pos,
  output logic [CNT_W-1:0] vblank_count
);
  localparam int unsigned HALF = 16;

  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic          h_wrap;

  rtg_scan_counter #(.XW(XW), .YW(YW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .v_total(v_total),
    .x(x), .y(y), .h_wrap(h_wrap)
  );

  rtg_sync_decode #(.CW(XW)) u_hs (.cnt(x), .cfg(hsync_cfg), .sync_o(hsync));
  rtg_sync_decode #(.CW(YW)) u_vs (.cnt(y), .cfg(vsync_cfg), .sync_o(vsync));

  assign de           = (x < h_active) && (y < v_active);
  assign vblank_pulse = (y == v_active) && (x == '0);
  assign scan_pos     = {HALF'(x), HALF'(y)};

  rtg_blank_counter #(.CNT_W(CNT_W)) u_vbc (
    .clk(clk), .rst_n(rst_n), .tick(vblank_pulse), .count(vblank_count)
  );

  p_vb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |=> !vblank_pulse);
  p_vb_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |-> !de);
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] h_total = 13'd10, h_active = 13'd6;
  logic [11:0] v_total = 12'd6, v_active = 12'd4;
  logic [31:0] hsync_cfg = '0, vsync_cfg = '0;
  logic        hsync, vsync, de, vblank_pulse;
  logic [31:0] scan_pos;
  logic [15:0] vblank_count;
  int checks = 0, bad = 0;

  always #2 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .h_active(h_active),
    .v_total(v_total), .v_active(v_active), .hsync_cfg(hsync_cfg),
    .vsync_cfg(vsync_cfg), .hsync(hsync), .vsync(vsync), .de(de),
    .vblank_pulse(vblank_pulse), .scan_pos(scan_pos), .vblank_count(vblank_count)
  );

  function automatic logic [31:0] mk(input bit inv, input bit en,
                                     input int stop, input int start);
    mk = '0;
    mk[31] = inv;
    mk[30] = en;
    mk[28:16] = 13'(stop);
    mk[12:0] = 13'(start);
  endfunction

  function automatic bit exp_sync(input logic [31:0] c, input int pos, input bit vert);
    int s, e;
    bit act;
    s = vert ? int'(c[11:0]) : int'(c[12:0]);
    e = vert ? int'(c[27:16]) : int'(c[28:16]);
    act = (pos >= s) && (pos < e);
    return c[30] ? (act ^ c[31]) : c[31];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int ht, input int ha, input int vt, input int va,
                         input logic [31:0] hc, input logic [31:0] vc, input int ncyc);
    int mx, my, mcnt;
    rst_n = 1'b0;
    h_total = 13'(ht); h_active = 13'(ha);
    v_total = 12'(vt); v_active = 12'(va);
    hsync_cfg = hc; vsync_cfg = vc;
    @(negedge clk); @(negedge clk);
    chk("R1 scan_pos in reset", scan_pos, 0);
    chk("R1 count in reset", vblank_count, 0);
    rst_n = 1'b1;
    mx = 0; my = 0; mcnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      chk("R11/R2/R3 scan_pos", scan_pos, (longint'(mx) << 16) | longint'(my));
      chk("R4/R6/R7 hsync", hsync, exp_sync(hc, mx, 1'b0));
      chk("R5/R6/R7 vsync", vsync, exp_sync(vc, my, 1'b1));
      chk("R8 de", de, (mx < ha) && (my < va));
      chk("R9 vblank_pulse", vblank_pulse, (my == va) && (mx == 0));
      chk("R10 vblank_count", vblank_count, mcnt & 16'hffff);
      @(posedge clk);
      if (my == va && mx == 0) mcnt++;
      if (mx == ht - 1) begin
        mx = 0;
        my = (my == vt - 1) ? 0 : my + 1;
      end else mx++;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    bad++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // plain polarity, both enabled
    run_cfg(10, 6, 6, 4, mk(0, 1, 9, 7), mk(0, 1, 5, 4), 185);
    // both inverted
    run_cfg(10, 6, 6, 4, mk(1, 1, 9, 7), mk(1, 1, 5, 4), 130);
    // hsync disabled and inverted, vsync disabled and plain
    run_cfg(7, 5, 5, 3, mk(1, 0, 6, 2), mk(0, 0, 4, 1), 110);
    // empty windows (start == end), window reaching the wrap
    run_cfg(7, 5, 5, 3, mk(0, 1, 3, 3), mk(0, 1, 5, 3), 110);
    run_cfg(7, 7, 5, 3, mk(0, 1, 7, 0), mk(1, 1, 2, 2), 80);
    // v_active beyond v_total: never blanks
    run_cfg(7, 4, 5, 9, mk(0, 1, 3, 1), mk(0, 1, 2, 0), 90);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule